// File: doc/BRIEF.md
# Microcoded Control Word Sequencer

This block turns an instruction opcode and a timing phase into the control strobes of a small processor. The two inputs are joined into a table address, with the opcode on top and the four phase bits at the bottom, so each opcode owns sixteen consecutive words. The addressed 16-bit word is read from a microcode table held inside the block as synthesizable logic. The word is then split into four independent bits and four 3-bit banks. Each bank is decoded one-of-eight into one-hot strobes.

A reset puts the block into a boot mode. In boot mode the opcode input is ignored and opcode 0x00 is used instead, so the boot words at addresses 0x000 to 0x00F run straight from the table. Boot mode ends on the clock edge that completes its last phase. From then on the external opcode is used. A sticky flag records any cycle in which the table produced a code that the PC/system bank does not define.

Top module: `ucode_seq`

## Requirements
- R1: The table address is {opcode, phase}, with phase in bits 3:0. The strobes follow the address in the same cycle, with no register between them.
- R2: Word bits drive four independent outputs: bit 15 haltEarly, bit 14 addrSelMar, bit 13 pcInc and bit 12 pulseReq.
- R3: ALU bank, bits 11:9. Code c from 1 to 7 asserts aluStb[c-1] (1 pass, 2 add, 3 sub, 4 and, 5 or, 6 xor, 7 instruction load). Code 0 asserts nothing.
- R4: PC/system bank, bits 8:6. Code 1 asserts pcStb[0] (clear), 2 asserts pcStb[1] (preset), 4 asserts pcStb[3] (MDR drive), 5 asserts pcStb[4] (system halt) and 6 asserts pcStb[5] (output load). Codes 0, 3 and 7 assert nothing, so pcStb[2] and pcStb[6] stay 0.
- R5: Memory bank, bits 5:3. Code c from 1 to 7 asserts memStb[c-1] (ROM drive, RAM drive, RAM write, MAR low load, MAR high load, MAR load, output drive). Code 0 asserts nothing.
- R6: Register bank, bits 2:0. Code c from 1 to 7 asserts regStb[c-1] (load A, B, C; drive A, B, C; MDR load). Code 0 asserts nothing.
- R7: At most one strobe is active in each bank in any cycle.
- R8: Boot mode works as follows.
  - It is set by rst.
  - While rst is high or boot mode is set, the table sees opcode 0x00.
  - Boot mode clears on a rising edge at which rst is low and phase is 15.
- R9: Boot words (opcode 0x00) are as follows. Phase 0 holds 0x0040 (PC clear). Phase 15 holds 0x2000 (pcInc). All other phases hold 0x0000.
- R10: For every nonzero opcode, phase 0 holds the fetch word 0x2E08: pcInc, ROM drive and instruction load.
- R11: The listed words, as (opcode, phase) = word, are:
  - (01,1)=2009, (02,1)=200A, (03,1)=501C
  - (04,1)=0025, (04,2)=002E, (04,3)=4030, (04,4)=0017, (04,5)=0103, (04,6)=0238
  - (06,1)=0401
  - (07,1)=0680, (07,2)=0800, (07,3)=0A00, (07,4)=0C00
  - (08,1)=0184, (09,1)=0140
  - (0E,1)=01C0 and (0F,1)=00C0, which are diagnostic words carrying the unused PC codes 7 and 3.
- R12: Every other nonzero-opcode word, at phase 1 or above, is 0x8000 (haltEarly only).
- R13: illegalCode is 0 after reset. It is set on a rising edge at which the PC/system bank code is 3 or 7, and it then stays set until the next rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; enters boot mode and clears the flag |
| opcode | input | 8 | Current instruction opcode |
| phase | input | 4 | Timing phase within the instruction |
| haltEarly | output | 1 | Word bit 15: end the current phase early |
| addrSelMar | output | 1 | Word bit 14: MAR, not PC, drives the address |
| pcInc | output | 1 | Word bit 13: increment the PC |
| pulseReq | output | 1 | Word bit 12: request the intra-phase pulse |
| aluStb | output | 7 | One-hot ALU bank strobes |
| pcStb | output | 7 | One-hot PC/system bank strobes |
| memStb | output | 7 | One-hot memory bank strobes |
| regStb | output | 7 | One-hot register bank strobes |
| illegalCode | output | 1 | Sticky flag for an unused PC/system bank code |

## Verification
The hardest case to reach from the ports is the boot window. In that window the opcode input must be shown to have no effect, and the exit must happen on exactly one edge. The stimulus holds phase at 15 while rst is high, then drives nonzero opcodes whose real words are nonzero at every boot phase. It then checks that the first non-boot cycle already decodes the external opcode. The sticky flag is reached through the two diagnostic opcodes in the middle of an exhaustive sweep over all opcode and phase pairs. That sweep makes the flag's rise point and its persistence checkable against a running expectation, and a second reset then shows that it clears.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 8;
  localparam int PH_W   = 4;
  localparam int ADDR_W = OPC_W + PH_W;
  localparam int BANK_W = 3;
  localparam int CODES  = 1 << BANK_W;
  localparam int STB_W  = CODES - 1;
  localparam int BANKS  = 4;
  localparam int DIR_W  = WORD_W - BANKS * BANK_W;
  localparam int PC_BANK = 2;
  // PC/system bank codes that carry no meaning
  localparam logic [CODES-1:0] PC_DROP = 8'b1000_1000;

  typedef struct packed {
    logic forceZero;
  } seqCtl_t;

  function automatic logic [WORD_W-1:0] mkWord(
      input logic [DIR_W-1:0] dir, input logic [BANK_W-1:0] alu,
      input logic [BANK_W-1:0] pc, input logic [BANK_W-1:0] mem,
      input logic [BANK_W-1:0] rg);
    return {dir, alu, pc, mem, rg};
  endfunction
endpackage

// File: rtl/ucode_bank_decode.sv
module ucode_bank_decode #(
  parameter int W = 3,
  parameter logic [(1<<W)-1:0] DROP = '0
) (
  input  logic [W-1:0]      code,
  output logic [(1<<W)-2:0] strobe
);
  always_comb begin
    strobe = '0;
    for (int k = 1; k < (1 << W); k++) begin
      if (code == W'(k) && !DROP[k]) strobe[k-1] = 1'b1;
    end
  end
endmodule

// File: rtl/ucode_ctl.sv
module ucode_ctl
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   phase,
  input  logic [BANK_W-1:0] pcCode,
  output seqCtl_t           ctl,
  output logic              illegalCode
);
  logic bootMode;

  // boot mode: set by reset, left after the last boot phase
  always_ff @(posedge clk) begin
    if (rst) bootMode <= 1'b1;
    else if (bootMode && phase == '1) bootMode <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) illegalCode <= 1'b0;
    else if (PC_DROP[pcCode]) illegalCode <= 1'b1;
  end

  assign ctl.forceZero = rst | bootMode;
endmodule

// File: rtl/ucode_path.sv
module ucode_path
  import ucode_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [PH_W-1:0]   phase,
  input  seqCtl_t           ctl,
  output logic [DIR_W-1:0]  direct,
  output logic [STB_W-1:0]  aluStb,
  output logic [STB_W-1:0]  pcStb,
  output logic [STB_W-1:0]  memStb,
  output logic [STB_W-1:0]  regStb,
  output logic [BANK_W-1:0] pcCode
);
  logic [OPC_W-1:0]  effOpc;
  logic [ADDR_W-1:0] tblAddr;
  logic [7:0]        hiByte, loByte;
  logic [WORD_W-1:0] ctlWord;
  logic [STB_W-1:0]  stb [BANKS];

  function automatic logic [WORD_W-1:0] ucodeTable(input logic [ADDR_W-1:0] a);
    logic [OPC_W-1:0] op;
    logic [PH_W-1:0]  ph;
    op = a[ADDR_W-1:PH_W];
    ph = a[PH_W-1:0];
    if (op == '0) begin
      if (ph == '0) return mkWord(4'b0000, 3'd0, 3'd1, 3'd0, 3'd0);
      if (ph == '1) return mkWord(4'b0010, 3'd0, 3'd0, 3'd0, 3'd0);
      return '0;
    end
    if (ph == '0) return mkWord(4'b0010, 3'd7, 3'd0, 3'd1, 3'd0);
    case ({op, ph})
      {8'h01, 4'd1}: return mkWord(4'b0010, 3'd0, 3'd0, 3'd1, 3'd1);
      {8'h02, 4'd1}: return mkWord(4'b0010, 3'd0, 3'd0, 3'd1, 3'd2);
      {8'h03, 4'd1}: return mkWord(4'b0101, 3'd0, 3'd0, 3'd3, 3'd4);
      {8'h04, 4'd1}: return mkWord(4'b0000, 3'd0, 3'd0, 3'd4, 3'd5);
      {8'h04, 4'd2}: return mkWord(4'b0000, 3'd0, 3'd0, 3'd5, 3'd6);
      {8'h04, 4'd3}: return mkWord(4'b0100, 3'd0, 3'd0, 3'd6, 3'd0);
      {8'h04, 4'd4}: return mkWord(4'b0000, 3'd0, 3'd0, 3'd2, 3'd7);
      {8'h04, 4'd5}: return mkWord(4'b0000, 3'd0, 3'd4, 3'd0, 3'd3);
      {8'h04, 4'd6}: return mkWord(4'b0000, 3'd1, 3'd0, 3'd7, 3'd0);
      {8'h06, 4'd1}: return mkWord(4'b0000, 3'd2, 3'd0, 3'd0, 3'd1);
      {8'h07, 4'd1}: return mkWord(4'b0000, 3'd3, 3'd2, 3'd0, 3'd0);
      {8'h07, 4'd2}: return mkWord(4'b0000, 3'd4, 3'd0, 3'd0, 3'd0);
      {8'h07, 4'd3}: return mkWord(4'b0000, 3'd5, 3'd0, 3'd0, 3'd0);
      {8'h07, 4'd4}: return mkWord(4'b0000, 3'd6, 3'd0, 3'd0, 3'd0);
      {8'h08, 4'd1}: return mkWord(4'b0000, 3'd0, 3'd6, 3'd0, 3'd4);
      {8'h09, 4'd1}: return mkWord(4'b0000, 3'd0, 3'd5, 3'd0, 3'd0);
      {8'h0E, 4'd1}: return mkWord(4'b0000, 3'd0, 3'd7, 3'd0, 3'd0);
      {8'h0F, 4'd1}: return mkWord(4'b0000, 3'd0, 3'd3, 3'd0, 3'd0);
      default:       return mkWord(4'b1000, 3'd0, 3'd0, 3'd0, 3'd0);
    endcase
  endfunction

  assign effOpc  = ctl.forceZero ? '0 : opcode;
  assign tblAddr = {effOpc, phase};
  assign {hiByte, loByte} = ucodeTable(tblAddr);
  assign ctlWord = {hiByte, loByte};

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    localparam int LSB = gi * BANK_W;
    localparam logic [CODES-1:0] DROP = (gi == PC_BANK) ? PC_DROP : '0;
    ucode_bank_decode #(.W(BANK_W), .DROP(DROP)) u_dec (
      .code  (ctlWord[LSB +: BANK_W]),
      .strobe(stb[gi])
    );
  end

  assign regStb = stb[0];
  assign memStb = stb[1];
  assign pcStb  = stb[PC_BANK];
  assign aluStb = stb[3];
  assign direct = ctlWord[WORD_W-1 -: DIR_W];
  assign pcCode = ctlWord[PC_BANK*BANK_W +: BANK_W];
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [PH_W-1:0]  phase,
  output logic             haltEarly,
  output logic             addrSelMar,
  output logic             pcInc,
  output logic             pulseReq,
  output logic [STB_W-1:0] aluStb,
  output logic [STB_W-1:0] pcStb,
  output logic [STB_W-1:0] memStb,
  output logic [STB_W-1:0] regStb,
  output logic             illegalCode
);
  seqCtl_t           ctl;
  logic [DIR_W-1:0]  direct;
  logic [BANK_W-1:0] pcCode;

  ucode_ctl u_ctl (
    .clk(clk), .rst(rst), .phase(phase), .pcCode(pcCode),
    .ctl(ctl), .illegalCode(illegalCode)
  );

  ucode_path u_path (
    .opcode(opcode), .phase(phase), .ctl(ctl), .direct(direct),
    .aluStb(aluStb), .pcStb(pcStb), .memStb(memStb), .regStb(regStb),
    .pcCode(pcCode)
  );

  assign {haltEarly, addrSelMar, pcInc, pulseReq} = direct;
endmodule

// File: rtl/ucode_seq_checker.sv
module ucode_seq_checker
  import ucode_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  phase,
  input logic             haltEarly,
  input logic             pulseReq,
  input logic [STB_W-1:0] aluStb,
  input logic [STB_W-1:0] pcStb,
  input logic [STB_W-1:0] memStb,
  input logic [STB_W-1:0] regStb,
  input logic             illegalCode
);
  assert_bank_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(aluStb) && $onehot0(pcStb) && $onehot0(memStb) && $onehot0(regStb));

  assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    illegalCode |=> illegalCode);

  assert_flag_cleared_R13: assert property (@(posedge clk)
    rst |=> !illegalCode);

  assert_boot_first_step_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && phase == '0) |->
      (pcStb == 7'b0000001 && aluStb == '0 && memStb == '0 && regStb == '0));

  assert_pulse_with_ram_write_R11: assert property (@(posedge clk) disable iff (rst)
    pulseReq |-> memStb == 7'b0000100);

  assert_halt_alone_R12: assert property (@(posedge clk) disable iff (rst)
    haltEarly |-> (aluStb == '0 && pcStb == '0 && memStb == '0 && regStb == '0));
endmodule

bind ucode_seq ucode_seq_checker u_chk (
  .clk(clk), .rst(rst), .phase(phase), .haltEarly(haltEarly),
  .pulseReq(pulseReq), .aluStb(aluStb), .pcStb(pcStb), .memStb(memStb),
  .regStb(regStb), .illegalCode(illegalCode)
);

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = 8'h55;
  logic [3:0] phase = 4'hF;
  logic       haltEarly, addrSelMar, pcInc, pulseReq, illegalCode;
  logic [6:0] aluStb, pcStb, memStb, regStb;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucode_seq u_ucode_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .phase(phase),
    .haltEarly(haltEarly), .addrSelMar(addrSelMar), .pcInc(pcInc),
    .pulseReq(pulseReq), .aluStb(aluStb), .pcStb(pcStb), .memStb(memStb),
    .regStb(regStb), .illegalCode(illegalCode)
  );

  function automatic logic [15:0] expWord(input logic [7:0] op, input logic [3:0] ph);
    if (op == 8'h00) return (ph == 4'd0) ? 16'h0040 : (ph == 4'd15) ? 16'h2000 : 16'h0000;
    if (ph == 4'd0) return 16'h2E08;
    case ({op, ph})
      12'h011: return 16'h2009;  12'h021: return 16'h200A;
      12'h031: return 16'h501C;  12'h041: return 16'h0025;
      12'h042: return 16'h002E;  12'h043: return 16'h4030;
      12'h044: return 16'h0017;  12'h045: return 16'h0103;
      12'h046: return 16'h0238;  12'h061: return 16'h0401;
      12'h071: return 16'h0680;  12'h072: return 16'h0800;
      12'h073: return 16'h0A00;  12'h074: return 16'h0C00;
      12'h081: return 16'h0184;  12'h091: return 16'h0140;
      12'h0E1: return 16'h01C0;  12'h0F1: return 16'h00C0;
      default: return 16'h8000;
    endcase
  endfunction

  function automatic logic [6:0] dec(input logic [2:0] c, input bit pcBank);
    if (c == 3'd0) return 7'd0;
    if (pcBank && (c == 3'd3 || c == 3'd7)) return 7'd0;
    return 7'd1 << (c - 3'd1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic [7:0] op, input logic [3:0] ph);
    @(negedge clk);
    rst = r; opcode = op; phase = ph;
    #2;
  endtask

  function automatic logic [31:0] actPack();
    return {haltEarly, addrSelMar, pcInc, pulseReq, aluStb, pcStb, memStb, regStb};
  endfunction

  function automatic logic [31:0] expPack(input logic [15:0] w);
    return {w[15:12], dec(w[11:9], 1'b0), dec(w[8:6], 1'b1), dec(w[5:3], 1'b0), dec(w[2:0], 1'b0)};
  endfunction

  initial begin
    bit expFlag;
    string tag;
    logic [15:0] w;
    logic [31:0] a, e;
    repeat (3) @(posedge clk);
    // reset held with phase 15: boot stays, opcode forced to zero
    apply(1'b1, 8'h55, 4'd15);
    chk("R8 opcode forced during reset", actPack(), expPack(16'h2000));
    chk("R13 flag clear in reset", 32'(illegalCode), 32'd0);
    apply(1'b0, 8'h55, 4'd0);
    chk("R9 boot step 0 clears PC", actPack(), expPack(16'h0040));
    for (int p = 1; p < 15; p++) begin
      apply(1'b0, 8'h07, 4'(p));
      chk("R8 opcode ignored in boot", actPack(), expPack(16'h0000));
    end
    apply(1'b0, 8'h04, 4'd15);
    chk("R9 boot last step increments PC", actPack(), expPack(16'h2000));
    apply(1'b0, 8'h01, 4'd1);
    chk("R8 boot released after phase 15", actPack(), expPack(16'h2009));

    // exhaustive sweep, table address {opcode, phase}
    expFlag = 1'b0;
    for (int op = 0; op < 256; op++) begin
      for (int ph = 0; ph < 16; ph++) begin
        apply(1'b0, 8'(op), 4'(ph));
        w = expWord(8'(op), 4'(ph));
        a = actPack();
        e = expPack(w);
        chk("R2 direct bits", 32'(a[31:28]), 32'(e[31:28]));
        chk("R3 ALU bank", 32'(a[27:21]), 32'(e[27:21]));
        chk("R4 PC bank", 32'(a[20:14]), 32'(e[20:14]));
        chk("R5 memory bank", 32'(a[13:7]), 32'(e[13:7]));
        chk("R6 register bank", 32'(a[6:0]), 32'(e[6:0]));
        chk("R7 one strobe per bank",
            32'(($countones(aluStb) <= 1) && ($countones(pcStb) <= 1) &&
                ($countones(memStb) <= 1) && ($countones(regStb) <= 1)), 32'd1);
        tag = (op == 0) ? "R1 R9 word" : (ph == 0) ? "R1 R10 word" :
              (w == 16'h8000) ? "R1 R12 word" : "R1 R11 word";
        chk(tag, a, e);
        chk("R13 sticky flag", 32'(illegalCode), 32'(expFlag));
        if (w[8:6] == 3'd3 || w[8:6] == 3'd7) expFlag = 1'b1;
      end
    end
    apply(1'b0, 8'h00, 4'd1);
    chk("R13 flag set after unused codes", 32'(illegalCode), 32'd1);
    apply(1'b1, 8'h09, 4'd1);
    apply(1'b0, 8'h09, 4'd1);
    chk("R13 flag cleared by reset", 32'(illegalCode), 32'd0);
    chk("R8 boot re-entered after reset", actPack(), expPack(16'h0000));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule